// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block keeps the byte count that governs a DMA transfer on a storage bus controller. Software writes the count one byte at a time into a host-side copy. A DMA command copies that host copy into a live copy. A transfer-information command then works out how many bytes the transfer will really move. That length is bounded by the command buffer while a command is being collected, and by the size of the outstanding residual otherwise. The block then counts that length down, one step for each byte the data path moves.

When the count runs out, the block raises the terminal-count flag and pulses a done strobe for one cycle. It also tracks the signed residual toward zero, and it reports the transfer direction from the residual's sign. Reads of the live count go through a small registered read port. The high byte of that port returns a fixed identification value until software first writes the high byte after reset. The memory accesses themselves belong to another block. This block only issues the length and observes the byte strobe.

Top module: `dma_len_counter`

## Requirements
- R1: After reset, `remain` is 0, `busy`, `tc`, `done` and `to_device` are 0, `resid_left` is 0, and `rd_data` is 0.
- R2: A write with `wr_addr` 0, 1 or 2 stores `wr_data` into the host copy of the low, middle or high count byte. On the next edge it clears `tc`, unless a completion (R9, R11) falls in the same cycle. A write to address 3 has no effect.
- R3: A read with `rd_addr` 0, 1 or 2 places the live low, middle or high count byte on `rd_data` one cycle later. Address 3 reads 0. While the high byte has not been written since reset, address 2 reads the identification value `CHIP_ID` (default 8'h5A). A write and a read of the high byte in the same cycle still return the identification value.
- R4: `cmd_valid` with `cmd_dma` copies all three host bytes into the live count. The host copy is taken before any write that lands in the same cycle. The live count is the low byte, plus the middle byte shifted left by 8, plus the high byte shifted left by 16.
- R5: A transfer start is `cmd_valid`, `cmd_dma` and `cmd_xfer` together. On the next edge, `remain` takes the effective length and `resid_left` takes `resid_in`. `to_device` becomes 1 exactly when `resid_in` is negative. `busy` becomes 1 when the length is nonzero, and `tc` is cleared when the length is nonzero.
- R6: The effective length uses the count just loaded by that same command. If the count is zero, it is taken as 65536.
- R7: With `cmd_mode` set, the effective length is the smaller of the count and `CMDBUF` (default 32). With `cmd_mode` clear, it is the smaller of the count and the magnitude of `resid_in`.
- R8: Each `byte_stb` while `busy` decrements `remain` by one and moves `resid_left` one step toward zero. A residual already at zero stays at zero. A `byte_stb` while not busy changes nothing.
- R9: The strobe that takes `remain` from 1 to 0 clears `busy` and sets `tc` on the next edge. It also drives `done` high for exactly that one cycle. Setting `tc` this way takes priority over a clearing write in the same cycle.
- R10: `cmd_xfer` without `cmd_dma` starts nothing and reloads nothing. A `byte_stb` in the same cycle as a transfer start is ignored.
- R11: A transfer start whose effective length is 0 (data mode, `resid_in` = 0) leaves `busy` at 0, sets `tc` and pulses `done` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Count byte write strobe |
| wr_addr | input | 2 | Byte select for write: 0 low, 1 middle, 2 high |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Byte select for read |
| rd_data | output | 8 | Registered read data |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | Command carries the DMA flag |
| cmd_xfer | input | 1 | Command is a transfer-information command |
| cmd_mode | input | 1 | 1 while collecting command bytes |
| resid_in | input | 25 | Signed residual size; negative means toward device |
| byte_stb | input | 1 | One byte moved |
| remain | output | 25 | Bytes left in the current transfer |
| busy | output | 1 | Transfer in progress |
| tc | output | 1 | Terminal count flag |
| done | output | 1 | One-cycle pulse at completion |
| to_device | output | 1 | Direction of the current transfer |
| resid_left | output | 25 | Signed residual being tracked |

## Verification
Two functions can fall in the same cycle. The final byte strobe sets the terminal flag, and a host write to a count byte clears it. The bench drives both in one cycle and expects `tc` to read 1 afterwards. It also lands a transfer start on the same cycle as a byte strobe, and expects the new length to be loaded without the decrement. The random phase raises writes, reads, commands and strobes independently every cycle, so further overlaps occur. An overlap of note is a reload using the host copy from before a same-cycle write. A cycle-accurate model in the bench judges every cycle.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  // Number of count bytes and default sizing shared by the block
  localparam int unsigned DEF_CNT_BYTES = 3;
  localparam int unsigned DEF_CMDBUF    = 32;
  localparam int unsigned DEF_ZERO_LEN  = 65536;
  localparam logic [7:0]  DEF_CHIP_ID   = 8'h5A;
endpackage

// File: rtl/tlc_count_regs.sv
module tlc_count_regs #(
  parameter int unsigned NB      = 3,
  parameter int unsigned AW      = 2,
  parameter logic [7:0]  CHIP_ID = 8'h5A
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  input  logic            load,
  output logic [8*NB-1:0] shadow_cnt,
  output logic [8*NB-1:0] live_cnt,
  output logic            cnt_wr,
  output logic [7:0]      rd_data
);
  localparam logic [AW-1:0] HI_IDX = AW'(NB-1);
  localparam logic [AW-1:0] NB_IDX = AW'(NB);

  logic [7:0] sh_q   [NB];
  logic [7:0] live_q [NB];
  logic       hi_wr_q;

  assign cnt_wr = wr_en && (wr_addr < NB_IDX);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q[b]   <= 8'h00;
        live_q[b] <= 8'h00;
      end else begin
        if (wr_en && wr_addr == AW'(b)) sh_q[b] <= wr_data;
        if (load) live_q[b] <= sh_q[b];
      end
    end
    assign shadow_cnt[8*b +: 8] = sh_q[b];
    assign live_cnt[8*b +: 8]   = live_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) hi_wr_q <= 1'b0;
    else if (wr_en && wr_addr == HI_IDX) hi_wr_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else if (rd_en) begin
      if (rd_addr >= NB_IDX)                      rd_data <= 8'h00;
      else if (rd_addr == HI_IDX && !hi_wr_q)     rd_data <= CHIP_ID;
      else                                        rd_data <= live_q[rd_addr];
    end
  end

  // R3
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_addr == HI_IDX && !hi_wr_q |=> rd_data == CHIP_ID);

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> live_cnt == $past(shadow_cnt));
endmodule

// File: rtl/tlc_len_calc.sv
module tlc_len_calc #(
  parameter int unsigned CW       = 24,
  parameter int unsigned RW       = 25,
  parameter int unsigned CMDBUF   = 32,
  parameter int unsigned ZERO_LEN = 65536
) (
  input  logic [CW-1:0]        cnt_in,
  input  logic                 cmd_mode,
  input  logic signed [RW-1:0] resid,
  output logic [RW-1:0]        eff_len
);
  logic [RW-1:0] cnt_x;
  logic [RW-1:0] mag;
  logic [RW-1:0] lim;

  always_comb begin
    cnt_x   = (cnt_in == '0) ? RW'(ZERO_LEN) : RW'(cnt_in);
    mag     = resid[RW-1] ? RW'(-resid) : RW'(resid);
    lim     = cmd_mode ? RW'(CMDBUF) : mag;
    eff_len = (cnt_x < lim) ? cnt_x : lim;
  end
endmodule

// File: rtl/tlc_down_counter.sv
module tlc_down_counter #(
  parameter int unsigned RW = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [RW-1:0]        eff_len,
  input  logic signed [RW-1:0] resid_in,
  input  logic                 byte_stb,
  input  logic                 cnt_wr,
  output logic [RW-1:0]        remain,
  output logic                 busy,
  output logic                 tc,
  output logic                 done,
  output logic                 to_device,
  output logic signed [RW-1:0] resid_left
);
  logic term;
  logic step;

  assign step = busy && byte_stb && !start;
  assign term = step && remain == RW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain     <= '0;
      busy       <= 1'b0;
      tc         <= 1'b0;
      done       <= 1'b0;
      to_device  <= 1'b0;
      resid_left <= '0;
    end else if (start) begin
      remain     <= eff_len;
      busy       <= (eff_len != '0);
      tc         <= (eff_len == '0);
      done       <= (eff_len == '0);
      to_device  <= resid_in[RW-1];
      resid_left <= resid_in;
    end else begin
      done <= term;
      if (step) begin
        remain <= remain - RW'(1);
        if (resid_left[RW-1])        resid_left <= resid_left + RW'(1);
        else if (resid_left != '0)   resid_left <= resid_left - RW'(1);
        if (term) busy <= 1'b0;
      end
      if (term)        tc <= 1'b1;
      else if (cnt_wr) tc <= 1'b0;
    end
  end

  // R5
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> remain == $past(eff_len));

  // R8
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    busy && byte_stb && !start |=> remain == $past(remain) - RW'(1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(remain) && $stable(resid_left));

  // R9
  done_state_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> tc && !busy && remain == '0);

  // R2
  tc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr && !start && !term |=> !tc);
endmodule

// File: rtl/dma_len_counter.sv
module dma_len_counter
  import tlc_pkg::*;
#(
  parameter int unsigned CNT_BYTES = DEF_CNT_BYTES,
  parameter int unsigned CMDBUF    = DEF_CMDBUF,
  parameter int unsigned ZERO_LEN  = DEF_ZERO_LEN,
  parameter logic [7:0]  CHIP_ID   = DEF_CHIP_ID,
  localparam int unsigned CW = 8 * CNT_BYTES,
  localparam int unsigned RW = CW + 1,
  localparam int unsigned AW = $clog2(CNT_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic [7:0]           rd_data,
  input  logic                 cmd_valid,
  input  logic                 cmd_dma,
  input  logic                 cmd_xfer,
  input  logic                 cmd_mode,
  input  logic signed [RW-1:0] resid_in,
  input  logic                 byte_stb,
  output logic [RW-1:0]        remain,
  output logic                 busy,
  output logic                 tc,
  output logic                 done,
  output logic                 to_device,
  output logic signed [RW-1:0] resid_left
);
  logic          load;
  logic          start;
  logic          cnt_wr;
  logic [CW-1:0] shadow_cnt;
  logic [CW-1:0] live_cnt;
  logic [CW-1:0] cnt_src;
  logic [RW-1:0] eff_len;

  assign load    = cmd_valid && cmd_dma;
  assign start   = load && cmd_xfer;
  assign cnt_src = load ? shadow_cnt : live_cnt;

  tlc_count_regs #(.NB(CNT_BYTES), .AW(AW), .CHIP_ID(CHIP_ID)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .load(load),
    .shadow_cnt(shadow_cnt), .live_cnt(live_cnt),
    .cnt_wr(cnt_wr), .rd_data(rd_data)
  );

  tlc_len_calc #(.CW(CW), .RW(RW), .CMDBUF(CMDBUF), .ZERO_LEN(ZERO_LEN)) u_len (
    .cnt_in(cnt_src), .cmd_mode(cmd_mode), .resid(resid_in), .eff_len(eff_len)
  );

  tlc_down_counter #(.RW(RW)) u_cnt (
    .clk(clk), .rst(rst),
    .start(start), .eff_len(eff_len), .resid_in(resid_in),
    .byte_stb(byte_stb), .cnt_wr(cnt_wr),
    .remain(remain), .busy(busy), .tc(tc), .done(done),
    .to_device(to_device), .resid_left(resid_left)
  );

  // R10
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_xfer && !cmd_dma && !busy |=> !busy && remain == $past(remain));
endmodule

// File: tb/test_dma_len_counter.sv
module test_dma_len_counter;
  localparam logic [7:0] ID = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0, cmd_valid = 0, cmd_dma = 0, cmd_xfer = 0;
  logic        cmd_mode = 0, byte_stb = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [7:0]  wr_data = 0;
  logic signed [24:0] resid_in = '0;
  logic [7:0]  rd_data;
  logic [24:0] remain;
  logic        busy, tc, done, to_device;
  logic signed [24:0] resid_left;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  logic [7:0] m_sh [3];
  logic [7:0] m_live [3];
  bit m_hiw, m_tc, m_busy, m_done, m_dir;
  longint m_rem, m_res;
  logic [7:0] m_rd;

  always #2 clk = ~clk;

  dma_len_counter i_dma_len_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer), .cmd_mode(cmd_mode),
    .resid_in(resid_in), .byte_stb(byte_stb), .remain(remain), .busy(busy), .tc(tc),
    .done(done), .to_device(to_device), .resid_left(resid_left)
  );

  function automatic longint eff_len(longint cnt, bit mode, longint res);
    longint c = (cnt == 0) ? 65536 : cnt;
    longint lim = mode ? 32 : ((res < 0) ? -res : res);
    return (c < lim) ? c : lim;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "remain", longint'(remain), m_rem);
    chk(tag, "busy", longint'(busy), longint'(m_busy));
    chk(tag, "tc", longint'(tc), longint'(m_tc));
    chk(tag, "done", longint'(done), longint'(m_done));
    chk(tag, "to_device", longint'(to_device), longint'(m_dir));
    chk(tag, "resid_left", longint'(resid_left), m_res);
    chk(tag, "rd_data", longint'(rd_data), longint'(m_rd));
  endtask

  task automatic step(string tag, bit wr, logic [1:0] wa, logic [7:0] wd,
                      bit rd, logic [1:0] ra, bit cv, bit cd, bit cx, bit cm,
                      longint rs, bit bs);
    bit ld, st, term;
    longint cnt, e;
    logic [7:0] old_sh [3];
    @(negedge clk);
    wr_en = wr; wr_addr = wa; wr_data = wd; rd_en = rd; rd_addr = ra;
    cmd_valid = cv; cmd_dma = cd; cmd_xfer = cx; cmd_mode = cm;
    resid_in = rs[24:0]; byte_stb = bs;
    @(posedge clk);
    ld = cv && cd;
    st = ld && cx;
    for (int b = 0; b < 3; b++) old_sh[b] = m_sh[b];
    cnt = ld ? longint'({old_sh[2], old_sh[1], old_sh[0]})
             : longint'({m_live[2], m_live[1], m_live[0]});
    e = eff_len(cnt, cm, rs);
    term = m_busy && bs && !st && m_rem == 1;
    if (rd) m_rd = (ra == 3) ? 8'h00 : ((ra == 2 && !m_hiw) ? ID : m_live[ra]);
    if (ld) for (int b = 0; b < 3; b++) m_live[b] = old_sh[b];
    if (wr && wa != 3) m_sh[wa] = wd;
    if (wr && wa == 2) m_hiw = 1;
    if (st) begin
      m_rem = e; m_busy = (e != 0); m_tc = (e == 0); m_done = (e == 0);
      m_dir = (rs < 0); m_res = rs;
    end else begin
      m_done = term;
      if (m_busy && bs) begin
        m_rem--;
        if (m_res < 0) m_res++; else if (m_res > 0) m_res--;
        if (term) m_busy = 0;
      end
      if (term) m_tc = 1;
      else if (wr && wa != 3) m_tc = 0;
    end
    #1;
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr_byte(string tag, logic [1:0] a, logic [7:0] d);
    step(tag, 1, a, d, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd_byte(string tag, logic [1:0] a);
    step(tag, 0, 0, 0, 1, a, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic go(string tag, bit cd, bit cx, bit cm, longint rs);
    step(tag, 0, 0, 0, 0, 0, 1, cd, cx, cm, rs, 0);
  endtask

  task automatic strobe(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4711));
    for (int b = 0; b < 3; b++) begin m_sh[b] = 0; m_live[b] = 0; end
    m_hiw = 0; m_tc = 0; m_busy = 0; m_done = 0; m_dir = 0; m_rem = 0; m_res = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1 compare("R1");

    // R3 identification value before high byte is written, address 3 reads zero
    rd_byte("R3", 2'd2);
    rd_byte("R3", 2'd3);
    // R6 zero count means 65536, data mode toward device
    go("R6", 1, 1, 0, -100000);
    // R11 zero effective length
    go("R11", 1, 1, 0, 0);
    idle("R11");
    // R2 count write clears tc
    wr_byte("R2", 2'd0, 8'd10);
    wr_byte("R2", 2'd3, 8'd99);
    // R4 dma command without transfer reloads live
    go("R4", 1, 0, 0, 0);
    rd_byte("R4", 2'd0);
    rd_byte("R3", 2'd2);
    // R3 same-cycle write and read of high byte still gives identification value
    step("R3", 1, 2'd2, 8'h00, 1, 2'd2, 0, 0, 0, 0, 0, 0);
    rd_byte("R3", 2'd2);
    // R7 command mode clamp: count 100 vs buffer 32
    wr_byte("R7", 2'd0, 8'd100);
    go("R7", 1, 1, 1, 0);
    // R7 data mode clamp by positive residual 3
    go("R7", 1, 1, 0, 3);
    strobe("R8");
    // R10 strobe in same cycle as a start is ignored
    step("R10", 0, 0, 0, 0, 0, 1, 1, 1, 0, 3, 1);
    // R10 transfer without DMA flag is ignored
    go("R10", 0, 1, 0, 50);
    strobe("R8");
    strobe("R8");
    // R9 last strobe together with a count write: tc stays set
    step("R9", 1, 2'd1, 8'd0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R9");
    // R8 strobe while idle has no effect
    strobe("R8");
    // R5 negative residual, count 100 clamps to 4
    go("R5", 1, 1, 0, -4);
    for (int i = 0; i < 4; i++) strobe("R8,R9");
    idle("R9");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit wr = ($urandom % 6) == 0;
      bit rd = ($urandom % 3) == 0;
      bit cv = ($urandom % 12) == 0;
      longint rs = longint'($urandom % 81) - 40;
      step("R2,R3,R4,R5,R7,R8,R9,R10,R11", wr, 2'($urandom % 4), 8'($urandom),
           rd, 2'($urandom % 4), cv, ($urandom % 4) != 0, ($urandom % 2) == 0,
           ($urandom % 3) == 0, rs, ($urandom % 3) != 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule